// File: doc/BRIEF.md
# Four-Channel Serial Audio Port

This block is the serial audio edge of a synthesis chip. From the core clock it derives a bit clock and a word select. It drives two serial data lines, which together carry four output channels, and it receives one stereo serial input line. Every frame lasts exactly 1024 core clocks. On each line the frame holds 64 bit periods, split into a left slot of 32 bits and a right slot of 32 bits. The sample rate is therefore the core clock divided by 1024.

Four parallel 20-bit output samples are taken in once per frame, at the frame boundary. The format select and the width select are taken in at the same moment. The format choice is either a delayed-by-one-bit (I2S) alignment or a right-justified alignment. The width choice is 16, 18 or 20 significant output bits. At the same boundary the 16-bit stereo pair captured during the previous frame is published, and a one-cycle frame strobe marks the event. Software or a DSP core uses this strobe as its cue to present the next four samples and to read the received pair.

Top module: `serial_audio_port`

## Requirements
- R1: The bit clock has a period of 16 core clocks. It is low for the first 8 core cycles of each bit period and high for the last 8, so that every bit period starts with a falling edge.
- R2: A frame is 1024 core clocks, which is 64 bit periods. Bit periods 0 to 31 form the left slot and bit periods 32 to 63 form the right slot. The frame strobe recurs every 1024 core clocks.
- R3: In I2S format (format input 0), word select is high during bit periods 31 to 62 and low otherwise. It therefore leads each slot by one bit period, and it changes only when the bit clock falls.
- R4: In right-justified format (format input 1), word select is low throughout the left slot (bit periods 0 to 31) and high throughout the right slot (bit periods 32 to 63).
- R5: Width code 0 selects 16 bits, code 1 selects 18 bits, and codes 2 and 3 select 20 bits. The serial word is the W most significant bits of the 20-bit parallel sample. Slot bits outside the word are 0.
- R6: In I2S format the word's MSB occupies slot bit 0. In right-justified format the word's LSB occupies slot bit 31. Bits go out MSB first.
- R7: Data line 0 carries the pair tx0_l/tx0_r and data line 1 carries the pair tx1_l/tx1_r. Both data lines change only in the core cycle in which the bit clock falls.
- R8: The input line is sampled once per bit period, in the core cycle in which the bit clock is first high. The input word is 16 bits, MSB first. It occupies slot bits 0 to 15 in I2S format and slot bits 16 to 31 in right-justified format.
- R9: The parallel samples, the format select and the width select are taken in only at the clock edge that ends core cycle 1023 of a frame. A change to any of them at another time has no effect on the frame in progress.
- R10: The input pair captured during a frame appears on rx_l/rx_r at that same frame-end edge, and it then stays constant for the whole next frame.
- R11: frame_stb is high for exactly one core cycle: the first cycle of every frame after the first one.
- R12: During and after reset, all outputs are 0, the sample holding registers are 0, and the format and width are I2S and 16 bits until the first frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 1024 times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_rj | input | 1 | 0 = I2S alignment, 1 = right-justified alignment |
| width_sel | input | 2 | Output word width code: 0 = 16, 1 = 18, 2 or 3 = 20 |
| tx0_l | input | 20 | Left sample for data line 0 |
| tx0_r | input | 20 | Right sample for data line 0 |
| tx1_l | input | 20 | Left sample for data line 1 |
| tx1_r | input | 20 | Right sample for data line 1 |
| sd_in | input | 1 | Serial stereo input line |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, low for left |
| sd_out0 | output | 1 | Serial data line 0 |
| sd_out1 | output | 1 | Serial data line 1 |
| rx_l | output | 16 | Received left sample |
| rx_r | output | 16 | Received right sample |
| frame_stb | output | 1 | One-cycle frame boundary pulse |

## Verification
The frame boundary is the one cycle where several functions coincide. In that cycle the new samples and modes are latched, the captured input pair is published, and the strobe rises. The bench provokes this by changing the parallel samples exactly in core cycle 1023. It also changes the format and width in the middle of a frame, and feeds a random input bit stream throughout. A behavioural model computes the expected value of every output on every core cycle, and the bench compares the design against it. Any mix-up between the old and new frame values at that boundary therefore appears as a mismatch on the serial lines or on rx_l/rx_r.

// File: rtl/serial_audio_port.sv
`timescale 1ns/1ps
module serial_audio_port #(
  parameter int DIV   = 16,
  parameter int SLOTW = 32,
  parameter int SW    = 20,
  parameter int IW    = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt_rj,
  input  logic [1:0]    width_sel,
  input  logic [SW-1:0] tx0_l,
  input  logic [SW-1:0] tx0_r,
  input  logic [SW-1:0] tx1_l,
  input  logic [SW-1:0] tx1_r,
  input  logic          sd_in,
  output logic          bclk,
  output logic          ws,
  output logic          sd_out0,
  output logic          sd_out1,
  output logic [IW-1:0] rx_l,
  output logic [IW-1:0] rx_r,
  output logic          frame_stb
);
  localparam int HALF  = DIV / 2;
  localparam int FRAME = DIV * 2 * SLOTW;
  localparam int CW    = $clog2(FRAME);
  localparam int PW    = $clog2(DIV);
  localparam int SLW   = $clog2(SLOTW);
  localparam int BW    = SLW + 1;
  localparam int SIW   = $clog2(SW);
  localparam int RIW   = $clog2(IW);

  logic [CW-1:0]  cnt;
  logic [PW-1:0]  ph;
  logic [SLW-1:0] pos;
  logic           chan, last;
  logic [BW-1:0]  nb;
  logic [SW-1:0]  h0l, h0r, h1l, h1r, s0, s1;
  logic           rj;
  logic [1:0]     wsel;
  logic [IW-1:0]  cap_l, cap_r;
  int             wlen, st, off, ist, ioff;
  logic           tx_hit, rx_hit;
  logic [SIW-1:0] tidx;
  logic [RIW-1:0] ridx;

  assign ph   = cnt[PW-1:0];
  assign pos  = cnt[PW+SLW-1:PW];
  assign chan = cnt[CW-1];
  assign last = (cnt == CW'(FRAME - 1));
  assign nb   = cnt[CW-1:PW] + BW'(1);

  assign bclk = ph[PW-1];
  assign ws   = rj ? chan : nb[BW-1];

  always_comb begin
    case (wsel)
      2'd0:    wlen = SW - 4;
      2'd1:    wlen = SW - 2;
      default: wlen = SW;
    endcase
  end

  assign st     = rj ? (SLOTW - wlen) : 0;
  assign off    = int'(pos) - st;
  assign tx_hit = (off >= 0) && (off < wlen);
  assign tidx   = tx_hit ? SIW'(SW - 1 - off) : '0;
  assign s0     = chan ? h0r : h0l;
  assign s1     = chan ? h1r : h1l;
  assign sd_out0 = tx_hit & s0[tidx];
  assign sd_out1 = tx_hit & s1[tidx];

  assign ist    = rj ? (SLOTW - IW) : 0;
  assign ioff   = int'(pos) - ist;
  assign rx_hit = (ioff >= 0) && (ioff < IW);
  assign ridx   = rx_hit ? RIW'(IW - 1 - ioff) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      frame_stb <= 1'b0;
      h0l <= '0; h0r <= '0; h1l <= '0; h1r <= '0;
      rj        <= 1'b0;
      wsel      <= 2'd0;
      cap_l     <= '0;
      cap_r     <= '0;
      rx_l      <= '0;
      rx_r      <= '0;
    end else begin
      cnt       <= last ? '0 : cnt + CW'(1);
      frame_stb <= last;
      if (ph == PW'(HALF) && rx_hit) begin
        if (chan) cap_r[ridx] <= sd_in;
        else      cap_l[ridx] <= sd_in;
      end
      if (last) begin
        h0l  <= tx0_l;
        h0r  <= tx0_r;
        h1l  <= tx1_l;
        h1r  <= tx1_r;
        rj   <= fmt_rj;
        wsel <= width_sel;
        rx_l <= cap_l;
        rx_r <= cap_r;
      end
    end
  end
endmodule

// File: rtl/serial_audio_port_chk.sv
`timescale 1ns/1ps
module serial_audio_port_chk #(
  parameter int DIV   = 16,
  parameter int SLOTW = 32,
  parameter int IW    = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          bclk,
  input logic          ws,
  input logic          sd_out0,
  input logic          sd_out1,
  input logic [IW-1:0] rx_l,
  input logic [IW-1:0] rx_r,
  input logic          frame_stb
);
  localparam int FRAME = DIV * 2 * SLOTW;
  logic prev_bclk;
  int   bgap, fgap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bclk <= 1'b0;
      bgap      <= 0;
      fgap      <= 0;
    end else begin
      prev_bclk <= bclk;
      if (bclk != prev_bclk) begin
        AST_BCLK_HALF: assert (bgap == DIV / 2) else $error("bit clock half period %0d", bgap); // R1
        bgap <= 1;
      end else bgap <= bgap + 1;
      if (frame_stb) begin
        AST_FRAME_LEN: assert (fgap == FRAME) else $error("frame length %0d", fgap); // R2
        fgap <= 1;
      end else fgap <= fgap + 1;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |=> !frame_stb); // R11
  AST_STB_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |-> $fell(bclk)); // R11
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_stb |-> ($stable(rx_l) && $stable(rx_r))); // R10
  AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(sd_out0) || !$stable(sd_out1)) |-> $fell(bclk)); // R7
  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ws) |-> $fell(bclk)); // R3
endmodule

bind serial_audio_port serial_audio_port_chk #(.DIV(DIV), .SLOTW(SLOTW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .sd_out0(sd_out0), .sd_out1(sd_out1),
  .rx_l(rx_l), .rx_r(rx_r), .frame_stb(frame_stb)
);

// File: tb/test_serial_audio_port.sv
`timescale 1ns/1ps
module test_serial_audio_port;
  logic clk = 0, rst_n = 0, fmt_rj = 0, sd_in = 0;
  logic [1:0] width_sel = 0;
  logic [19:0] tx0_l = 0, tx0_r = 0, tx1_l = 0, tx1_r = 0;
  logic bclk, ws, sd_out0, sd_out1, frame_stb;
  logic [15:0] rx_l, rx_r;

  serial_audio_port i_serial_audio_port (
    .clk(clk), .rst_n(rst_n), .fmt_rj(fmt_rj), .width_sel(width_sel),
    .tx0_l(tx0_l), .tx0_r(tx0_r), .tx1_l(tx1_l), .tx1_r(tx1_r), .sd_in(sd_in),
    .bclk(bclk), .ws(ws), .sd_out0(sd_out0), .sd_out1(sd_out1),
    .rx_l(rx_l), .rx_r(rx_r), .frame_stb(frame_stb)
  );

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit chk_en = 0, done = 0;

  // behavioural reference state
  int t = 0;
  bit [19:0] mh [0:3];
  bit mrj = 0;
  int mw = 16;
  bit [31:0] capw [0:1];
  bit [15:0] mrx [0:1];
  bit mstb = 0;

  function automatic int width_of(logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : 20;
  endfunction

  task automatic model_reset();
    t = 0; mrj = 0; mw = 16; mstb = 0;
    for (int i = 0; i < 4; i++) mh[i] = 0;
    for (int i = 0; i < 2; i++) begin capw[i] = 0; mrx[i] = 0; end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (t % 16 == 8) capw[(t / 16) / 32][31 - ((t / 16) % 32)] = sd_in;
      if (t == 1023) begin
        for (int c = 0; c < 2; c++) mrx[c] = mrj ? capw[c][15:0] : capw[c][31:16];
        mh[0] = tx0_l; mh[1] = tx0_r; mh[2] = tx1_l; mh[3] = tx1_r;
        mrj = fmt_rj; mw = width_of(width_sel);
        mstb = 1;
      end else mstb = 0;
      t = (t + 1) % 1024;
    end
  end

  function automatic bit exp_bit(bit [19:0] s, int w, bit rj, int p);
    bit [31:0] word;
    word = 32'(s >> (20 - w));
    if (!rj) word = word << (32 - w);
    return word[31 - p];
  endfunction

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s at t=%0d: actual=%0h expected=%0h", tag, nm, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      int b, p, ch;
      b = t / 16; p = b % 32; ch = b / 32;
      chk("R1", "bclk", int'(bclk), int'((t % 16) >= 8));
      if (mrj) chk("R2 R4", "ws", int'(ws), ch);
      else     chk("R2 R3", "ws", int'(ws), int'(((b + 1) % 64) >= 32));
      chk("R5 R6 R7 R9", "sd_out0", int'(sd_out0), int'(exp_bit(mh[ch], mw, mrj, p)));
      chk("R5 R6 R7 R9", "sd_out1", int'(sd_out1), int'(exp_bit(mh[2 + ch], mw, mrj, p)));
      chk("R8 R10", "rx_l", int'(rx_l), int'(mrx[0]));
      chk("R8 R10", "rx_r", int'(rx_r), int'(mrx[1]));
      chk("R2 R11", "frame_stb", int'(frame_stb), int'(mstb));
    end
  end

  task automatic new_tx();
    tx0_l = 20'($urandom); tx0_r = 20'($urandom);
    tx1_l = 20'($urandom); tx1_r = 20'($urandom);
  endtask

  initial begin
    bit [1:0] wl [0:7];
    bit       fl [0:7];
    wl = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3};
    fl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    new_tx();
    fmt_rj = 1; width_sel = 2;
    repeat (3) @(negedge clk);
    // R12: outputs quiet while reset is held, even with inputs active
    chk("R12", "bclk", int'(bclk), 0);
    chk("R12", "ws", int'(ws), 0);
    chk("R12", "sd_out0", int'(sd_out0), 0);
    chk("R12", "sd_out1", int'(sd_out1), 0);
    chk("R12", "rx_l", int'(rx_l), 0);
    chk("R12", "rx_r", int'(rx_r), 0);
    chk("R12", "frame_stb", int'(frame_stb), 0);
    rst_n = 1;
    chk_en = 1;
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 2048; k++) begin
        @(negedge clk);
        sd_in = 1'($urandom);
        if (k == 300) begin fmt_rj = fl[m]; width_sel = wl[m]; end  // R9 mid-frame change
        if (t == 1023 || ($urandom % 211) == 0) new_tx();           // R9 boundary coincidence
      end
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule